// File: doc/BRIEF.md
# Raster Target Scan Sequencer

This block walks a programmable box of output-pixel coordinates in raster order. It runs across u, then down v, and for three-axis work it also steps through planes in w. For every output pixel it runs a kernel walk of programmable length. Each step of the walk presents one coefficient-table address and an accumulate strobe. An external multiply-accumulate unit uses these to build the resampled pixel value. A write strobe then tells the unit to store the result. With k taps, one output pixel is finished every k clock cycles, with no idle cycle between pixels.

Software sets the bounds, the tap count and the mode through a small register port while the sequencer is idle. A start pulse loads every counter with its lower bound and begins the scan. At the end of the scan the block either halts with a done flag or wraps back to the lower bounds and keeps going, as the mode selects. Source-coordinate arithmetic, the pixel datapath and the memories are outside this block.

Top module: `tscan_seq`

## Requirements
- R1: While reset (rst_n low, sampled synchronously) is applied, and after it is released with no start, every output is zero.
- R2: When cfg_we is high and no scan is running, cfg_data is stored in the register chosen by cfg_sel, and the next scan uses the stored values. The cfg_sel codes are: 0 u lower bound, 1 u upper bound, 2 v lower bound, 3 v upper bound, 4 w lower bound, 5 w upper bound, 6 tap count minus one (cfg_data[7:0]), 7 mode (bit 0 = three-axis scan, bit 1 = repeat).
- R3: A register write made while a scan is running is ignored. The running scan and a later restart without reprogramming both use the old values.
- R4: A start pulse loads u, v and w with their lower bounds and clears the tap counter. In the next cycle acc_en is high and kern_addr is 0.
- R5: While scanning, acc_en is high every cycle. kern_addr counts 0 up to the tap count minus one, one step per cycle, and the coordinates stay fixed during each walk. Up to 256 taps are supported.
- R6: tgt_wr is high for exactly the one cycle after each walk's last tap.
- R7: After the last tap, u advances by one. After u reaches its upper bound, u reloads its lower bound and v advances.
- R8: In two-axis mode (mode bit 0 = 0), the scan ends after the pixel at (u upper, v upper), and w holds its lower bound throughout.
- R9: In three-axis mode, w advances after each completed plane, and the scan ends after the pixel at the u, v and w upper bounds.
- R10: In halt mode (mode bit 1 = 0), scan_done rises in the cycle of the final tgt_wr. In that cycle acc_en is low, kern_addr is 0, and the coordinates hold the last pixel. All of these persist until the next start.
- R11: In repeat mode, the cycle after the last tap of the final pixel begins a new pass at the lower bounds with no gap. scan_done stays low.
- R12: frame_end pulses together with the tgt_wr of the final pixel of each pass.
- R13: A start pulse during a scan restarts it from the lower bounds in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_sel | input | 3 | Register select |
| cfg_data | input | 13 | Register write data |
| start | input | 1 | Load lower bounds and begin scanning |
| tgt_u | output | 13 | Current target u coordinate |
| tgt_v | output | 13 | Current target v coordinate |
| tgt_w | output | 13 | Current target w coordinate |
| kern_addr | output | 8 | Coefficient-table address of the current tap |
| acc_en | output | 1 | Accumulate strobe, high on every walk step |
| tgt_wr | output | 1 | Target write strobe for the pixel just walked |
| frame_end | output | 1 | Marks the write of a pass's final pixel |
| scan_done | output | 1 | Scan finished in halt mode |

## Verification
Every cycle of each scan is compared with a reference built from nested loops over w, v, u and tap. The scans use offset two-axis boxes, a three-axis box, a single pixel and a one-tap kernel, which separate errors in row wrap, plane stepping and tap handling. A single pixel with a 256-tap kernel probes the walk counter at its full range. A nonzero w lower bound in two-axis mode shows whether w wrongly moves. Directed runs cover a register write mid-scan, two back-to-back passes in repeat mode, and a restart issued mid-scan.

// File: rtl/tscan_pkg.sv
// Package tscan_pkg
// Shared widths, register select codes, mode bit positions and axis
// indices for the raster target scan sequencer.
package tscan_pkg;
    localparam int COORD_W  = 13;
    localparam int KADR_W   = 8;
    localparam int NUM_AXES = 3;

    // Register select codes; axis a uses 2a (lower) and 2a+1 (upper).
    localparam logic [2:0] SEL_KERN = 3'd6;
    localparam logic [2:0] SEL_MODE = 3'd7;

    // Mode register bit positions.
    localparam int MODE_3D  = 0;
    localparam int MODE_RPT = 1;

    typedef enum logic [1:0] {AX_U = 2'd0, AX_V = 2'd1, AX_W = 2'd2} axis_e;
endpackage

// File: rtl/tscan_cfg.sv
// Module tscan_cfg
// Holds the scan configuration: per-axis lower/upper bounds, tap count
// minus one and mode bits. Assumes the caller gates wr_en so that writes
// only land while no scan runs. Assumes KW <= CW.
module tscan_cfg #(
    parameter int CW  = 13,
    parameter int KW  = 8,
    parameter int NAX = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    wr_en,
    input  logic [2:0]              sel,
    input  logic [CW-1:0]           data,
    output logic [NAX-1:0][CW-1:0]  lo,
    output logic [NAX-1:0][CW-1:0]  hi,
    output logic [KW-1:0]           kern_m1,
    output logic                    is_3d,
    output logic                    rpt
);
    import tscan_pkg::*;

    for (genvar a = 0; a < NAX; a++) begin : g_axis_reg
        logic [CW-1:0] lo_q;
        logic [CW-1:0] hi_q;

        // Capture this axis's bounds on a matching idle write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                lo_q <= '0;
                hi_q <= '0;
            end else if (wr_en && sel == 3'(2 * a)) begin
                lo_q <= data;
            end else if (wr_en && sel == 3'(2 * a + 1)) begin
                hi_q <= data;
            end
        end

        assign lo[a] = lo_q;
        assign hi[a] = hi_q;
    end

    // Capture tap count and mode bits on a matching idle write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kern_m1 <= '0;
            is_3d   <= 1'b0;
            rpt     <= 1'b0;
        end else if (wr_en && sel == SEL_KERN) begin
            kern_m1 <= data[KW-1:0];
        end else if (wr_en && sel == SEL_MODE) begin
            is_3d <= data[MODE_3D];
            rpt   <= data[MODE_RPT];
        end
    end
endmodule

// File: rtl/tscan_walk.sv
// Module tscan_walk
// Kernel tap counter. Counts 0..last_m1 while run is high, wrapping to 0
// after the last tap. Assumes load and run are not both needed at once;
// load wins.
module tscan_walk #(
    parameter int KW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          run,
    input  logic [KW-1:0] last_m1,
    output logic [KW-1:0] tap,
    output logic          tap_last
);
    // Flag the final tap of the current walk.
    always_comb tap_last = run && (tap == last_m1);

    // Advance the tap index or clear it on load and after the last tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tap <= '0;
        end else if (load) begin
            tap <= '0;
        end else if (run) begin
            tap <= tap_last ? '0 : tap + 1'b1;
        end
    end
endmodule

// File: rtl/tscan_axis.sv
// Module tscan_axis
// One target coordinate counter. Loads its lower bound, steps by one and
// wraps from the upper bound back to the lower bound. Assumes lo <= hi.
module tscan_axis #(
    parameter int CW = 13
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          step,
    input  logic [CW-1:0] lo,
    input  logic [CW-1:0] hi,
    output logic [CW-1:0] val,
    output logic          at_hi
);
    // Report that the coordinate sits on its upper bound.
    always_comb at_hi = (val == hi);

    // Load, advance or wrap the coordinate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            val <= '0;
        end else if (load) begin
            val <= lo;
        end else if (step) begin
            val <= at_hi ? lo : val + 1'b1;
        end
    end
endmodule

// File: rtl/tscan_seq.sv
// Module tscan_seq
// Raster target scan sequencer: raster-walks u/v(/w) over a programmed
// box, running a kernel walk of programmable length per pixel, with
// accumulate and write strobes for an external multiply-accumulate unit.
// Assumes each lower bound is not above its upper bound. tgt_wr refers to
// the pixel whose coordinates were shown in the previous cycle.
module tscan_seq #(
    parameter int COORD_W = tscan_pkg::COORD_W,
    parameter int KADR_W  = tscan_pkg::KADR_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [2:0]         cfg_sel,
    input  logic [COORD_W-1:0] cfg_data,
    input  logic               start,
    output logic [COORD_W-1:0] tgt_u,
    output logic [COORD_W-1:0] tgt_v,
    output logic [COORD_W-1:0] tgt_w,
    output logic [KADR_W-1:0]  kern_addr,
    output logic               acc_en,
    output logic               tgt_wr,
    output logic               frame_end,
    output logic               scan_done
);
    import tscan_pkg::*;

    localparam int NAX = NUM_AXES;

    logic [NAX-1:0][COORD_W-1:0] cfg_lo;
    logic [NAX-1:0][COORD_W-1:0] cfg_hi;
    logic [NAX-1:0][COORD_W-1:0] axis_val;
    logic [KADR_W-1:0]           kern_m1;
    logic                        is_3d;
    logic                        rpt;
    logic [NAX-1:0]              at_hi;
    logic [NAX-1:0]              step;
    logic                        busy;
    logic                        done_q;
    logic                        wr_q;
    logic                        fe_q;
    logic                        tap_last;
    logic                        last_pix;
    logic                        halt_now;
    logic                        cfg_wr;
    logic [KADR_W-1:0]           tap;

    // Accept register writes only while idle.
    always_comb cfg_wr = cfg_we && !busy;

    tscan_cfg #(.CW(COORD_W), .KW(KADR_W), .NAX(NAX)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr),
        .sel     (cfg_sel),
        .data    (cfg_data),
        .lo      (cfg_lo),
        .hi      (cfg_hi),
        .kern_m1 (kern_m1),
        .is_3d   (is_3d),
        .rpt     (rpt)
    );

    tscan_walk #(.KW(KADR_W)) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (start),
        .run      (busy),
        .last_m1  (kern_m1),
        .tap      (tap),
        .tap_last (tap_last)
    );

    // Decide end of pass and the carry chain across the axes.
    always_comb begin
        last_pix = at_hi[AX_U] && at_hi[AX_V] && (at_hi[AX_W] || !is_3d);
        halt_now = tap_last && last_pix && !rpt;
        step[AX_U] = tap_last && !halt_now;
        step[AX_V] = step[AX_U] && at_hi[AX_U];
        step[AX_W] = step[AX_V] && at_hi[AX_V] && is_3d;
    end

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        tscan_axis #(.CW(COORD_W)) u_axis (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (start),
            .step  (step[a]),
            .lo    (cfg_lo[a]),
            .hi    (cfg_hi[a]),
            .val   (axis_val[a]),
            .at_hi (at_hi[a])
        );
    end

    // Run/done state and the registered write and end-of-pass strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy   <= 1'b0;
            done_q <= 1'b0;
            wr_q   <= 1'b0;
            fe_q   <= 1'b0;
        end else begin
            wr_q <= tap_last;
            fe_q <= tap_last && last_pix;
            if (start) begin
                busy   <= 1'b1;
                done_q <= 1'b0;
            end else if (halt_now) begin
                busy   <= 1'b0;
                done_q <= 1'b1;
            end
        end
    end

    // Drive the outputs from state.
    always_comb begin
        tgt_u     = axis_val[AX_U];
        tgt_v     = axis_val[AX_V];
        tgt_w     = axis_val[AX_W];
        kern_addr = tap;
        acc_en    = busy;
        tgt_wr    = wr_q;
        frame_end = fe_q;
        scan_done = done_q;
    end
endmodule

// File: rtl/tscan_seq_chk.sv
// Module tscan_seq_chk
// Temporal checks on the sequencer's ports and configuration state,
// bound into tscan_seq. Assumes programmed bounds satisfy lo <= hi.
module tscan_seq_chk #(
    parameter int CW = 13,
    parameter int KW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          acc_en,
    input logic [KW-1:0] kern_addr,
    input logic          tgt_wr,
    input logic          frame_end,
    input logic          scan_done,
    input logic [CW-1:0] tgt_u,
    input logic [CW-1:0] u_lo,
    input logic [CW-1:0] u_hi,
    input logic [KW-1:0] kern_m1
);
    // R5: taps advance one per cycle inside a walk
    a_r5_tap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && !start && kern_addr != kern_m1) |=> (kern_addr == $past(kern_addr) + 1'b1));

    // R6: a write only follows a walk's last tap
    a_r6_wr_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        tgt_wr |-> ($past(acc_en) && $past(kern_addr) == $past(kern_m1)));

    // R6: with more than one tap the write strobe lasts one cycle
    a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
        (tgt_wr && kern_m1 != '0 && !start) |=> !tgt_wr);

    // R10: done never overlaps walking
    a_r10_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        scan_done |-> !acc_en);

    // R12: end of pass coincides with a write
    a_r12_fe_with_wr: assert property (@(posedge clk) disable iff (!rst_n)
        frame_end |-> tgt_wr);

    // R3: configuration frozen while scanning
    a_r3_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && $past(acc_en)) |-> ($stable(u_hi) && $stable(kern_m1)));

    // R7: u stays within its bounds while walking
    a_r7_u_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        acc_en |-> (tgt_u >= u_lo && tgt_u <= u_hi));
endmodule

bind tscan_seq tscan_seq_chk #(.CW(COORD_W), .KW(KADR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .acc_en    (acc_en),
    .kern_addr (kern_addr),
    .tgt_wr    (tgt_wr),
    .frame_end (frame_end),
    .scan_done (scan_done),
    .tgt_u     (tgt_u),
    .u_lo      (cfg_lo[0]),
    .u_hi      (cfg_hi[0]),
    .kern_m1   (kern_m1)
);

// File: tb/tscan_seq_tb.sv
module tscan_seq_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CW = 13;
    localparam int KW = 8;
    localparam int OBS_W = 3 * CW + KW + 4;

    typedef struct packed {
        logic [CW-1:0] ulo, uhi, vlo, vhi, wlo, whi;
        logic [KW-1:0] km1;
        logic          three;
    } scn_t;

    // Stimulus table: each entry is programmed, started and checked cycle by cycle.
    localparam scn_t SCN [6] = '{
        '{13'd2, 13'd4, 13'd1, 13'd2, 13'd0,  13'd0,  8'd0,   1'b0},
        '{13'd0, 13'd2, 13'd5, 13'd6, 13'd9,  13'd12, 8'd2,   1'b0},
        '{13'd1, 13'd2, 13'd0, 13'd1, 13'd3,  13'd4,  8'd1,   1'b1},
        '{13'd7, 13'd7, 13'd3, 13'd3, 13'd0,  13'd0,  8'd3,   1'b0},
        '{13'd0, 13'd1, 13'd0, 13'd0, 13'd0,  13'd2,  8'd0,   1'b1},
        '{13'd5, 13'd5, 13'd6, 13'd6, 13'd1,  13'd1,  8'd255, 1'b1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic cfg_we = 1'b0;
    logic [2:0] cfg_sel = '0;
    logic [CW-1:0] cfg_data = '0;
    logic [CW-1:0] tgt_u, tgt_v, tgt_w;
    logic [KW-1:0] kern_addr;
    logic acc_en, tgt_wr, frame_end, scan_done;

    int n_chk = 0;
    int n_err = 0;
    logic exp_wr = 1'b0;
    logic exp_fe = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tscan_seq u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_data(cfg_data), .start(start), .tgt_u(tgt_u), .tgt_v(tgt_v),
        .tgt_w(tgt_w), .kern_addr(kern_addr), .acc_en(acc_en),
        .tgt_wr(tgt_wr), .frame_end(frame_end), .scan_done(scan_done)
    );

    function automatic logic [OBS_W-1:0] obs();
        return {tgt_u, tgt_v, tgt_w, kern_addr, acc_en, tgt_wr, frame_end, scan_done};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, expv);
        end
    endtask

    task automatic cfg_write(input logic [2:0] s, input logic [CW-1:0] d);
        cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R2: program all registers through the select codes
    task automatic load_scn(input scn_t s, input bit rpt);
        cfg_write(3'd0, s.ulo); cfg_write(3'd1, s.uhi);
        cfg_write(3'd2, s.vlo); cfg_write(3'd3, s.vhi);
        cfg_write(3'd4, s.wlo); cfg_write(3'd5, s.whi);
        cfg_write(3'd6, CW'(s.km1));
        cfg_write(3'd7, CW'({rpt, s.three}));
    endtask

    task automatic pulse_start();
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Reference loop model: one check per walk cycle of a whole pass.
    task automatic expect_frame(input scn_t s, input bit poke, input string tag);
        int whi_eff;
        bit first;
        whi_eff = s.three ? int'(s.whi) : int'(s.wlo);
        first = 1'b1;
        for (int w = int'(s.wlo); w <= whi_eff; w++)
            for (int v = int'(s.vlo); v <= int'(s.vhi); v++)
                for (int u = int'(s.ulo); u <= int'(s.uhi); u++)
                    for (int t = 0; t <= int'(s.km1); t++) begin
                        logic [OBS_W-1:0] e;
                        bit lastpix;
                        e = {CW'(u), CW'(v), CW'(w), KW'(t), 1'b1, exp_wr, exp_fe, 1'b0};
                        chk(obs() == e, tag, 64'(obs()), 64'(e));
                        lastpix = (u == int'(s.uhi)) && (v == int'(s.vhi)) && (w == whi_eff);
                        exp_wr = (t == int'(s.km1));
                        exp_fe = exp_wr && lastpix;
                        if (poke && first) begin
                            cfg_we = 1'b1; cfg_sel = 3'd1; cfg_data = s.uhi + 13'd5;
                        end
                        first = 1'b0;
                        @(negedge clk);
                        cfg_we = 1'b0;
                    end
    endtask

    // R10 R12: halt cycle and held done state
    task automatic expect_halt(input scn_t s);
        logic [OBS_W-1:0] e;
        logic [CW-1:0] wl;
        wl = s.three ? s.whi : s.wlo;
        e = {s.uhi, s.vhi, wl, KW'(0), 1'b0, 1'b1, 1'b1, 1'b1};
        chk(obs() == e, "R10 R12 final write and done", 64'(obs()), 64'(e));
        @(negedge clk);
        e = {s.uhi, s.vhi, wl, KW'(0), 1'b0, 1'b0, 1'b0, 1'b1};
        chk(obs() == e, "R10 done holds", 64'(obs()), 64'(e));
        exp_wr = 1'b0;
        exp_fe = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        scn_t r;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(obs() == '0, "R1 during reset", 64'(obs()), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(obs() == '0, "R1 after release", 64'(obs()), 64'(0));

        // Table walk: R2 R4 R5 R6 R7 R8 R9 R10 R12
        for (int i = 0; i < 6; i++) begin
            load_scn(SCN[i], 1'b0);
            pulse_start();
            expect_frame(SCN[i], 1'b0, "R2 R4 R5 R6 R7 R8 R9 sequence");
            expect_halt(SCN[i]);
        end

        // R3: write during scan ignored, now and on a restart
        load_scn(SCN[1], 1'b0);
        pulse_start();
        expect_frame(SCN[1], 1'b1, "R3 write while busy ignored");
        expect_halt(SCN[1]);
        pulse_start();
        expect_frame(SCN[1], 1'b0, "R3 old values kept on restart");
        expect_halt(SCN[1]);

        // R11 R12: repeat mode, two passes back to back
        r = '{13'd0, 13'd1, 13'd2, 13'd2, 13'd0, 13'd0, 8'd1, 1'b0};
        load_scn(r, 1'b1);
        pulse_start();
        expect_frame(r, 1'b0, "R11 repeat pass one");
        expect_frame(r, 1'b0, "R11 R12 repeat pass two");

        // R13: start mid-scan restarts from the lower bounds
        pulse_start();
        exp_wr = 1'b0;
        exp_fe = 1'b0;
        expect_frame(r, 1'b0, "R13 restart mid scan");

        // R1: reset mid-scan returns to zero
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(obs() == '0, "R1 reset mid scan", 64'(obs()), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(obs() == '0, "R1 idle after reset", 64'(obs()), 64'(0));

        finish_run();
    end
endmodule